// File: doc/BRIEF.md
# Swizzled Four-Channel Vector Adder

This block holds a bank of wide registers, each made of four 24-bit channels (named a, b, c and d), and adds two of them lane by lane in one cycle. Each source operand first passes through its own swizzle crossbar. The crossbar may reorder or replicate the source's channels into a temporary operand. The two temporaries are then added in four independent 24-bit two's-complement adders. A per-channel write mask decides which channels of the destination register take the new sums. The other channels keep their old contents.

The same add serves both 24-bit signed integers and s7.16 signed fixed-point values, because both use the same bit-level addition. Each lane reports signed overflow in the cycle the instruction issues. A separate full-register load port fills registers with operand values. The combinational lane sums are also brought out, so a caller can see the result of any register pair and swizzle pair without writing anything back.

Top module: `swz_vadd`

## Requirements
- R1: A synchronous active-low reset clears every register to zero, and the cleared values can be read in the first cycle after reset is released.
- R2: When `ld_en` is high at a rising clock edge, all 96 bits of `ld_data` are written into register `ld_idx`. Channel a sits at bits [23:0], b at [47:24], c at [71:48] and d at [95:72]; the same layout applies to `sum_o`.
- R3: Lane i of each temporary operand is the source channel named by swizzle bits [2i+1:2i], with a=0, b=1, c=2 and d=3. Entries may name the same channel more than once.
- R4: Lane i of `sum_o` is temp1 lane i plus temp2 lane i, wrapped modulo 2^24. The output is combinational and valid for all four lanes regardless of the mask.
- R5: On an accepted instruction, channel i of register `dst_idx` is replaced by sum lane i at the clock edge when `wmask` bit i is 1 (bit 0 = a, bit 3 = d). Channels whose mask bit is 0 keep their previous value.
- R6: `ovf_o` bit i is 1 during an accepted instruction exactly when lane i's true sum lies outside [-2^23, 2^23-1] and `wmask` bit i is 1.
- R7: When `issue_valid` is low, no register changes and `ovf_o` is zero.
- R8: A source register that is also the destination of the instruction in the same cycle is read with its old value; the new value appears from the next cycle on.
- R9: If `ld_en` and `issue_valid` are both high, only the load is performed; the instruction writes nothing and `ovf_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction present this cycle |
| src1_idx | input | 5 | First source register |
| src2_idx | input | 5 | Second source register |
| dst_idx | input | 5 | Destination register |
| swz1 | input | 8 | Swizzle of first source, 2 bits per lane |
| swz2 | input | 8 | Swizzle of second source, 2 bits per lane |
| wmask | input | 4 | Destination channel write mask |
| ld_en | input | 1 | Full-register load strobe |
| ld_idx | input | 5 | Load target register |
| ld_data | input | 96 | Load value |
| sum_o | output | 96 | Combinational lane sums of the swizzled sources |
| ovf_o | output | 4 | Per-lane signed overflow of the issuing instruction |

## Verification
The adder is driven with several swizzle pairs: the mixed replicating pair abab/bbaa, a full reversal against the identity, and a broadcast of one channel. A wrong lane-to-channel mapping shows up in at least one of these because the loaded channel values are all distinct. Overflow is tried with operand channels set to the positive limit, the negative limit, two halves that sum to exactly 2^23, and -1 plus 1. This separates positive overflow, negative overflow, the exact boundary and a harmless carry-out, under both a full and a partial mask. Partial masks, an idle issue, a destination that is also a source, and a load colliding with an issue show whether untouched channels and registers really stay unchanged.

// File: rtl/swz_vadd_pkg.sv
// Package: default geometry of the swizzled vector adder.
// Assumes the channel count is a power of two so a select field is exact.
package swz_vadd_pkg;
    localparam int DEF_CH_W     = 24;
    localparam int DEF_NUM_CH   = 4;
    localparam int DEF_NUM_REGS = 32;
    localparam int DEF_SEL_W    = $clog2(DEF_NUM_CH);
    localparam int DEF_IDX_W    = $clog2(DEF_NUM_REGS);
endpackage

// File: rtl/swz_regfile.sv
// Register file: NUM_REGS wide registers made of NUM_CH channels.
// Two combinational read ports return the stored value (old value on a
// same-cycle write); one synchronous write port with per-channel enables.
// Assumes NUM_REGS is a power of two.
module swz_regfile #(
    parameter int NUM_REGS = swz_vadd_pkg::DEF_NUM_REGS,
    parameter int NUM_CH   = swz_vadd_pkg::DEF_NUM_CH,
    parameter int CH_W     = swz_vadd_pkg::DEF_CH_W,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int REG_W   = NUM_CH * CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [REG_W-1:0] rd_a_data,
    output logic [REG_W-1:0] rd_b_data,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [NUM_CH-1:0] wr_ch_en,
    input  logic [REG_W-1:0] wr_data
);

    logic [REG_W-1:0] mem [NUM_REGS];

    // Storage update: clear on reset, otherwise write enabled channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                mem[r] <= '0;
            end
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_ch_en[c]) begin
                    mem[wr_idx][c*CH_W +: CH_W] <= wr_data[c*CH_W +: CH_W];
                end
            end
        end
    end

    // Read ports: plain array lookups, no bypass of the pending write.
    assign rd_a_data = mem[rd_a_idx];
    assign rd_b_data = mem[rd_b_idx];

    // R1: right after reset is released every read returns zero.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rd_a_data == '0 && rd_b_data == '0));

endmodule

// File: rtl/swz_crossbar.sv
// Swizzle crossbar: lane i of the output takes the input channel named by
// select field i. Any channel may feed any number of lanes.
// Assumes NUM_CH is a power of two (every select code names a channel).
module swz_crossbar #(
    parameter int NUM_CH  = swz_vadd_pkg::DEF_NUM_CH,
    parameter int CH_W    = swz_vadd_pkg::DEF_CH_W,
    localparam int SEL_W  = $clog2(NUM_CH),
    localparam int REG_W  = NUM_CH * CH_W
) (
    input  logic [REG_W-1:0]        src,
    input  logic [NUM_CH*SEL_W-1:0] swz,
    output logic [REG_W-1:0]        dst
);

    logic [CH_W-1:0] chan [NUM_CH];

    // Split the packed source into addressable channels.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            chan[c] = src[c*CH_W +: CH_W];
        end
    end

    // One multiplexer per lane driven by its own select field.
    for (genvar l = 0; l < NUM_CH; l++) begin : g_lane
        assign dst[l*CH_W +: CH_W] = chan[swz[l*SEL_W +: SEL_W]];
    end

endmodule

// File: rtl/swz_lane_add.sv
// One lane adder: two's-complement add of two CH_W-bit values, wrapping,
// with a signed overflow flag derived from the operand and result signs.
module swz_lane_add #(
    parameter int CH_W = swz_vadd_pkg::DEF_CH_W
) (
    input  logic [CH_W-1:0] op_a,
    input  logic [CH_W-1:0] op_b,
    output logic [CH_W-1:0] sum,
    output logic            ovf
);

    // Wrapping sum and sign-based overflow detection.
    always_comb begin
        sum = op_a + op_b;
        ovf = (op_a[CH_W-1] == op_b[CH_W-1]) && (sum[CH_W-1] != op_a[CH_W-1]);
    end

    // R6: flag agrees with a one-bit-wider exact sum falling out of range.
    always_comb begin
        if (!$isunknown({op_a, op_b})) begin
            p_no_overflow_r6: assert (ovf ==
                (($signed({op_a[CH_W-1], op_a}) + $signed({op_b[CH_W-1], op_b}))
                  > $signed({2'b00, {(CH_W-1){1'b1}}}) ||
                 ($signed({op_a[CH_W-1], op_a}) + $signed({op_b[CH_W-1], op_b}))
                  < $signed({2'b11, {(CH_W-1){1'b0}}})));
        end
    end

endmodule

// File: rtl/swz_vadd.sv
// Top: register file, two swizzle crossbars, NUM_CH lane adders and masked
// write-back. The load port takes the single write port when it is used;
// an instruction is accepted only when issue_valid is high and ld_en low.
module swz_vadd #(
    parameter int NUM_REGS = swz_vadd_pkg::DEF_NUM_REGS,
    parameter int NUM_CH   = swz_vadd_pkg::DEF_NUM_CH,
    parameter int CH_W     = swz_vadd_pkg::DEF_CH_W,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int SEL_W   = $clog2(NUM_CH),
    localparam int REG_W   = NUM_CH * CH_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue_valid,
    input  logic [IDX_W-1:0]        src1_idx,
    input  logic [IDX_W-1:0]        src2_idx,
    input  logic [IDX_W-1:0]        dst_idx,
    input  logic [NUM_CH*SEL_W-1:0] swz1,
    input  logic [NUM_CH*SEL_W-1:0] swz2,
    input  logic [NUM_CH-1:0]       wmask,
    input  logic                    ld_en,
    input  logic [IDX_W-1:0]        ld_idx,
    input  logic [REG_W-1:0]        ld_data,
    output logic [REG_W-1:0]        sum_o,
    output logic [NUM_CH-1:0]       ovf_o
);

    logic [REG_W-1:0]  rd1, rd2, tmp1, tmp2, lane_sum;
    logic [NUM_CH-1:0] lane_ovf;
    logic              accept;
    logic [IDX_W-1:0]  wr_idx;
    logic [NUM_CH-1:0] wr_ch_en;
    logic [REG_W-1:0]  wr_data;

    swz_regfile #(.NUM_REGS(NUM_REGS), .NUM_CH(NUM_CH), .CH_W(CH_W)) rf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (src1_idx),
        .rd_b_idx (src2_idx),
        .rd_a_data(rd1),
        .rd_b_data(rd2),
        .wr_idx   (wr_idx),
        .wr_ch_en (wr_ch_en),
        .wr_data  (wr_data)
    );

    swz_crossbar #(.NUM_CH(NUM_CH), .CH_W(CH_W)) xb1_i (
        .src(rd1), .swz(swz1), .dst(tmp1)
    );

    swz_crossbar #(.NUM_CH(NUM_CH), .CH_W(CH_W)) xb2_i (
        .src(rd2), .swz(swz2), .dst(tmp2)
    );

    for (genvar l = 0; l < NUM_CH; l++) begin : g_add
        swz_lane_add #(.CH_W(CH_W)) add_i (
            .op_a(tmp1[l*CH_W +: CH_W]),
            .op_b(tmp2[l*CH_W +: CH_W]),
            .sum (lane_sum[l*CH_W +: CH_W]),
            .ovf (lane_ovf[l])
        );
    end

    // Write-port arbitration: a load wins and suppresses the instruction.
    always_comb begin
        accept = issue_valid && !ld_en;
        if (ld_en) begin
            wr_idx   = ld_idx;
            wr_ch_en = '1;
            wr_data  = ld_data;
        end else begin
            wr_idx   = dst_idx;
            wr_ch_en = accept ? wmask : '0;
            wr_data  = lane_sum;
        end
    end

    // Outputs: raw lane sums and overflow of enabled lanes of an accepted op.
    assign sum_o = lane_sum;
    assign ovf_o = accept ? (lane_ovf & wmask) : '0;

    // R6: no overflow flag on a lane the mask leaves alone.
    p_ovf_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o & ~wmask) == '0);

    // R7: an idle cycle never reports overflow.
    p_ovf_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> ovf_o == '0);

    // R9: a colliding load silences the instruction's flags.
    p_load_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> ovf_o == '0);

endmodule

// File: tb/swz_vadd_tb_top.sv
// Directed bench: a reference model of the registers is kept here and
// every scenario task checks the design's ports against it.
module swz_vadd_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [4:0]  src1_idx = '0, src2_idx = '0, dst_idx = '0, ld_idx = '0;
    logic [7:0]  swz1 = '0, swz2 = '0;
    logic [3:0]  wmask = '0;
    logic        ld_en = 1'b0;
    logic [95:0] ld_data = '0;
    logic [95:0] sum_o;
    logic [3:0]  ovf_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [95:0] mdl [32];

    localparam logic [7:0] SW_ABCD = 8'hE4;
    localparam logic [7:0] SW_ABAB = 8'h44;
    localparam logic [7:0] SW_BBAA = 8'h05;
    localparam logic [7:0] SW_DCBA = 8'h1B;
    localparam logic [7:0] SW_CCCC = 8'hAA;
    localparam logic [4:0] ZREG    = 5'd31;

    always #10 clk = ~clk;

    swz_vadd dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .src1_idx(src1_idx), .src2_idx(src2_idx), .dst_idx(dst_idx),
        .swz1(swz1), .swz2(swz2), .wmask(wmask),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .sum_o(sum_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [95:0] pack4(input logic [23:0] a, input logic [23:0] b,
                                          input logic [23:0] c, input logic [23:0] d);
        return {d, c, b, a};
    endfunction

    // Expected sums and raw overflow from the requirement text.
    task automatic calc(input logic [95:0] v1, input logic [95:0] v2,
                        input logic [7:0] s1, input logic [7:0] s2,
                        output logic [95:0] s, output logic [3:0] o);
        for (int i = 0; i < 4; i++) begin
            logic [23:0] t1, t2;
            logic signed [24:0] w;
            t1 = v1[int'(s1[2*i +: 2])*24 +: 24];
            t2 = v2[int'(s2[2*i +: 2])*24 +: 24];
            w = $signed({t1[23], t1}) + $signed({t2[23], t2});
            s[i*24 +: 24] = w[23:0];
            o[i] = (w < -25'sd8388608) || (w > 25'sd8388607);
        end
    endtask

    task automatic peek(input logic [4:0] idx, input string tag);
        @(negedge clk);
        issue_valid = 1'b0; ld_en = 1'b0;
        src1_idx = idx; swz1 = SW_ABCD; src2_idx = ZREG; swz2 = SW_ABCD;
        #1;
        chk(tag, sum_o, mdl[idx]);
    endtask

    task automatic do_load(input logic [4:0] idx, input logic [95:0] v);
        @(negedge clk);
        issue_valid = 1'b0; ld_en = 1'b1; ld_idx = idx; ld_data = v;
        @(posedge clk);
        mdl[idx] = v;
        #1 ld_en = 1'b0;
    endtask

    // Issue one add, check comb outputs in the issue cycle, then the result.
    task automatic run_op(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d,
                          input logic [7:0] s1, input logic [7:0] s2,
                          input logic [3:0] m, input string tag);
        logic [95:0] es, nv;
        logic [3:0]  eo;
        @(negedge clk);
        ld_en = 1'b0; issue_valid = 1'b1;
        src1_idx = a; src2_idx = b; dst_idx = d; swz1 = s1; swz2 = s2; wmask = m;
        calc(mdl[a], mdl[b], s1, s2, es, eo);
        #1;
        chk({tag, " sum"}, sum_o, es);
        chk({tag, " ovf"}, {92'b0, ovf_o}, {92'b0, eo & m});
        nv = mdl[d];
        for (int i = 0; i < 4; i++) if (m[i]) nv[i*24 +: 24] = es[i*24 +: 24];
        @(posedge clk);
        mdl[d] = nv;
        #1 issue_valid = 1'b0;
        peek(d, {tag, " writeback"});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        do_load(5'd5, pack4(24'h1, 24'h2, 24'h3, 24'h4));
        peek(5'd5, "R2 load before reset");
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int r = 0; r < 32; r++) mdl[r] = '0;
        peek(5'd5, "R1 reset clears R5");
        peek(5'd0, "R1 reset clears R0");
        peek(5'd30, "R1 reset clears R30");
    endtask

    task automatic t_swizzle;
        do_load(5'd1, pack4(24'h000011, 24'h000022, 24'h000033, 24'h000044));
        do_load(5'd2, pack4(24'h000100, 24'h000200, 24'h000300, 24'h000400));
        do_load(5'd3, pack4(24'hAAAAAA, 24'hBBBBBB, 24'hCCCCCC, 24'hDDDDDD));
        peek(5'd1, "R2 load R1");
        run_op(5'd1, 5'd2, 5'd3, SW_ABAB, SW_BBAA, 4'b0011, "R3 R5 abab+bbaa mask ab");
        run_op(5'd1, 5'd2, 5'd3, SW_DCBA, SW_ABCD, 4'b1111, "R3 R4 dcba+abcd full");
        run_op(5'd2, 5'd1, 5'd3, SW_CCCC, SW_DCBA, 4'b1010, "R3 R5 broadcast c mask bd");
    endtask

    task automatic t_overflow;
        do_load(5'd4, pack4(24'h7FFFFF, 24'h800000, 24'h400000, 24'hFFFFFF));
        do_load(5'd6, pack4(24'h000001, 24'h800000, 24'h400000, 24'h000001));
        run_op(5'd4, 5'd6, 5'd8, SW_ABCD, SW_ABCD, 4'b1111, "R4 R6 overflow full mask");
        run_op(5'd4, 5'd6, 5'd9, SW_ABCD, SW_ABCD, 4'b0101, "R6 R5 overflow partial mask");
    endtask

    task automatic t_idle;
        @(negedge clk);
        issue_valid = 1'b0; ld_en = 1'b0;
        src1_idx = 5'd4; src2_idx = 5'd6; dst_idx = 5'd1;
        swz1 = SW_ABCD; swz2 = SW_ABCD; wmask = 4'b1111;
        #1 chk("R7 idle ovf", {92'b0, ovf_o}, 96'b0);
        @(posedge clk);
        peek(5'd1, "R7 idle leaves R1");
    endtask

    task automatic t_same_reg;
        do_load(5'd7, pack4(24'h000005, 24'hFFFFF0, 24'h123456, 24'h000000));
        run_op(5'd7, 5'd7, 5'd7, SW_ABCD, SW_ABCD, 4'b0111, "R8 dst equals src old read");
        run_op(5'd7, 5'd7, 5'd7, SW_ABCD, SW_DCBA, 4'b1001, "R8 second use sees new value");
    endtask

    task automatic t_collide;
        logic [95:0] v;
        v = pack4(24'h00000A, 24'h00000B, 24'h00000C, 24'h00000D);
        @(negedge clk);
        issue_valid = 1'b1; ld_en = 1'b1; ld_idx = 5'd10; ld_data = v;
        src1_idx = 5'd4; src2_idx = 5'd6; dst_idx = 5'd1;
        swz1 = SW_ABCD; swz2 = SW_ABCD; wmask = 4'b1111;
        #1 chk("R9 collide ovf", {92'b0, ovf_o}, 96'b0);
        @(posedge clk);
        mdl[10] = v;
        #1 begin issue_valid = 1'b0; ld_en = 1'b0; end
        peek(5'd1, "R9 collide instruction dropped");
        peek(5'd10, "R9 collide load done");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < 32; r++) mdl[r] = '0;
        t_reset;
        t_swizzle;
        t_overflow;
        t_idle;
        t_same_reg;
        t_collide;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule